// File: doc/BRIEF.md
# ADC Post-Processing Event Flag Register

This block gathers sticky event flags for four ADC post-processing channels into one 16-bit status word that software can only read. Each channel delivers an end-of-conversion strobe, its signed post-processed result, and single-cycle pulses from its high and low digital-compare trips. For every channel the block keeps three flags: trip-high, trip-low and zero-crossing. The zero-crossing flag rises when the result's sign differs from the sign seen at that channel's previous end-of-conversion.

Software clears flags through a write-one-to-clear vector and masks them through a per-flag interrupt enable vector. The block raises one combined interrupt request level from the pending, enabled flags. A flag latches whether or not its enable bit is set, so a handler reads both the status word and its own enable vector to find the source. When a hardware event and a software clear hit the same flag in the same cycle, the event wins.

Top module: `adc_evt_flags`

## Requirements
- R1: Channel n (0..3) owns status bits [4n+3:4n]: bit 4n is trip-high, bit 4n+1 is trip-low, bit 4n+2 is zero-crossing, and bit 4n+3 is reserved and always reads 0.
- R2: While rst_n is low, every status bit goes to 0 at the clock edge and irq is 0.
- R3: A trip_hi[n] or trip_lo[n] pulse high at a rising clock edge sets that channel's trip-high or trip-low flag, and the flag is visible after that edge.
- R4: On a cycle with eoc[n] high, the result's sign is its MSB (bit 15 of channel n's 16-bit slice). If that sign differs from the sign stored at the previous eoc[n], the zero-crossing flag sets at that edge. Every eoc[n] stores the new sign.
- R5: A change in a channel's result on cycles where eoc[n] is low does not set the zero-crossing flag.
- R6: The first eoc[n] after reset only stores the sign and never sets the zero-crossing flag.
- R7: Flags are sticky and stay set until cleared, and they set even when the matching int_en bit is 0.
- R8: A 1 in clr clears the matching flag at the next clock edge. A 0 leaves it unchanged, and 1s at reserved positions change nothing.
- R9: When a flag's set event and its clr bit occur in the same cycle, the flag is set after that edge.
- R10: irq is high exactly when some status bit and its int_en bit are both 1. It stays high until every enabled pending flag is cleared or masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eoc | input | 4 | Per-channel end-of-conversion strobe |
| result | input | 64 | Per-channel signed result, channel n in bits [16n+15:16n] |
| trip_hi | input | 4 | Per-channel high compare trip pulse |
| trip_lo | input | 4 | Per-channel low compare trip pulse |
| clr | input | 16 | Write-one-to-clear vector, same layout as status |
| int_en | input | 16 | Per-flag interrupt enable, same layout as status |
| status | output | 16 | Sticky event flag word |
| irq | output | 1 | Combined interrupt request level |

## Verification
On every cycle the assertions check several properties. Reserved bits stay at zero. A trip pulse always leaves its flag set, which covers the collision with a simultaneous clear. A pending flag with no clear request stays set. A zero-crossing flag never rises after a cycle without end-of-conversion. irq never rises without an enabled pending flag and never drops while nothing is cleared and the enables hold. Only the directed scenarios can show the sign history: the first end-of-conversion after reset being ignored, repeated same-sign conversions raising nothing, and the exact flag values after partial clears and changes to the enable vector.

// File: rtl/adc_evt_pkg.sv
// Package: shared field layout of the event flag nibble.
// Assumes every channel uses the same 4-bit nibble with a reserved top bit.
package adc_evt_pkg;
    localparam int NIB_W   = 4;   // bits per channel in the status word
    localparam int LIVE_W  = 3;   // implemented flags per channel
    localparam int FLD_HI  = 0;   // trip-high position in nibble
    localparam int FLD_LO  = 1;   // trip-low position in nibble
    localparam int FLD_ZC  = 2;   // zero-crossing position in nibble
    localparam int FLD_RSV = 3;   // reserved position in nibble
endpackage

// File: rtl/adc_sign_tracker.sv
// Module: adc_sign_tracker
// Tracks one channel's result sign across end-of-conversion strobes and
// flags a sign change. Assumes the sign bit is already extracted (MSB).
// The first strobe after reset only primes the stored sign.
module adc_sign_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc,
    input  logic sign,
    output logic zc_evt
);
    logic last_sign;
    logic primed;

    // Store the sign on every strobe and remember that one has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_sign <= 1'b0;
            primed    <= 1'b0;
        end else if (eoc) begin
            last_sign <= sign;
            primed    <= 1'b1;
        end
    end

    // Sign change qualified by the strobe and a valid stored sign.
    always_comb begin
        zc_evt = eoc & primed & (sign ^ last_sign);
    end
endmodule

// File: rtl/adc_evt_nibble.sv
// Module: adc_evt_nibble
// Holds one channel's sticky flags. A set event beats a clear request in
// the same cycle. Assumes set inputs are single-cycle qualified events.
// The reserved bit of the nibble is a constant zero.
module adc_evt_nibble
    import adc_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_hi,
    input  logic              set_lo,
    input  logic              set_zc,
    input  logic [LIVE_W-1:0] clr_bits,
    output logic [NIB_W-1:0]  nib
);
    logic [LIVE_W-1:0] flags;
    logic [LIVE_W-1:0] set_vec;

    // Gather the set events into flag order.
    always_comb begin
        set_vec         = '0;
        set_vec[FLD_HI] = set_hi;
        set_vec[FLD_LO] = set_lo;
        set_vec[FLD_ZC] = set_zc;
    end

    // Sticky update: clear first, then let a set override it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_bits) | set_vec;
        end
    end

    // Place live flags and the zero reserved bit into the nibble.
    always_comb begin
        nib               = '0;
        nib[LIVE_W-1:0]   = flags;
        nib[FLD_RSV]      = 1'b0;
    end
endmodule

// File: rtl/adc_irq_merge.sv
// Module: adc_irq_merge
// Reduces the enabled pending flags to one interrupt request level.
// Assumes status and enable share the same bit layout.
module adc_irq_merge #(
    parameter int W = 16
) (
    input  logic [W-1:0] status,
    input  logic [W-1:0] en,
    output logic         irq
);
    // Level request: any flag that is both pending and enabled.
    always_comb begin
        irq = |(status & en);
    end
endmodule

// File: rtl/adc_evt_flags.sv
// Module: adc_evt_flags (top)
// Collects trip and zero-crossing event flags from NUM_CH post-processing
// channels into one read-only status word and drives a combined irq.
// Assumes trip inputs are synchronous single-cycle pulses and results are
// two's complement of RES_W bits.
module adc_evt_flags
    import adc_evt_pkg::*;
#(
    parameter  int NUM_CH = 4,
    parameter  int RES_W  = 16,
    localparam int STAT_W = NUM_CH * NIB_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       eoc,
    input  logic [NUM_CH*RES_W-1:0] result,
    input  logic [NUM_CH-1:0]       trip_hi,
    input  logic [NUM_CH-1:0]       trip_lo,
    input  logic [STAT_W-1:0]       clr,
    input  logic [STAT_W-1:0]       int_en,
    output logic [STAT_W-1:0]       status,
    output logic                    irq
);
    logic [NUM_CH-1:0] zc_evt;
    logic [NUM_CH-1:0] unused_fold;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        adc_sign_tracker u_sign (
            .clk    (clk),
            .rst_n  (rst_n),
            .eoc    (eoc[c]),
            .sign   (result[c*RES_W + RES_W-1]),
            .zc_evt (zc_evt[c])
        );

        adc_evt_nibble u_nib (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_hi   (trip_hi[c]),
            .set_lo   (trip_lo[c]),
            .set_zc   (zc_evt[c]),
            .clr_bits (clr[c*NIB_W +: LIVE_W]),
            .nib      (status[c*NIB_W +: NIB_W])
        );

        // Magnitude bits and reserved clear bits are not used by design.
        assign unused_fold[c] = ^{result[c*RES_W +: RES_W-1],
                                  clr[c*NIB_W + FLD_RSV]};
    end

    adc_irq_merge #(.W(STAT_W)) u_irq (
        .status (status),
        .en     (int_en),
        .irq    (irq)
    );
endmodule

// File: rtl/adc_evt_flags_chk.sv
// Module: adc_evt_flags_chk
// Checker bound to adc_evt_flags; observes its ports only.
module adc_evt_flags_chk
    import adc_evt_pkg::*;
#(
    parameter  int NUM_CH = 4,
    localparam int STAT_W = NUM_CH * NIB_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] eoc,
    input logic [NUM_CH-1:0] trip_hi,
    input logic [NUM_CH-1:0] trip_lo,
    input logic [STAT_W-1:0] clr,
    input logic [STAT_W-1:0] int_en,
    input logic [STAT_W-1:0] status,
    input logic              irq
);
    logic [NUM_CH-1:0] hi_bits, lo_bits, zc_bits, rsv_bits;

    // Split the status word into per-field vectors.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            hi_bits[c]  = status[c*NIB_W + FLD_HI];
            lo_bits[c]  = status[c*NIB_W + FLD_LO];
            zc_bits[c]  = status[c*NIB_W + FLD_ZC];
            rsv_bits[c] = status[c*NIB_W + FLD_RSV];
        end
    end

    // R1: reserved bits read zero
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_bits == '0);

    // R3 / R9: a trip-high pulse always leaves its flag set, clear or not
    a_r3_trip_hi_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|trip_hi) |=> ((hi_bits & $past(trip_hi)) == $past(trip_hi)));

    // R3 / R9: a trip-low pulse always leaves its flag set, clear or not
    a_r3_trip_lo_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|trip_lo) |=> ((lo_bits & $past(trip_lo)) == $past(trip_lo)));

    // R5: zero-crossing flags only rise after a strobe cycle
    a_r5_zc_needs_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((zc_bits & ~$past(zc_bits) & ~$past(eoc)) == '0));

    // R7: pending flags without a clear request stay set
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(status) & ~$past(clr))
                  == ($past(status) & ~$past(clr))));

    // R10: no request without an enabled pending flag
    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((status & int_en) != '0));

    // R10: request is a level that holds while nothing is cleared or masked
    a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq) && ($past(clr) == '0) && $stable(int_en)) |-> irq);
endmodule

bind adc_evt_flags adc_evt_flags_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .eoc     (eoc),
    .trip_hi (trip_hi),
    .trip_lo (trip_lo),
    .clr     (clr),
    .int_en  (int_en),
    .status  (status),
    .irq     (irq)
);

// File: tb/tb_adc_evt_flags.sv
// Directed bench for adc_evt_flags: one task per scenario.
module tb_adc_evt_flags;
    localparam int NCH = 4;
    localparam int RW  = 16;
    localparam int SW  = NCH * 4;
    localparam logic [15:0] POS = 16'h0100;
    localparam logic [15:0] NEG = 16'h8001;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NCH-1:0]  eoc;
    logic [NCH*RW-1:0] result;
    logic [NCH-1:0]  trip_hi, trip_lo;
    logic [SW-1:0]   clr, int_en;
    logic [SW-1:0]   status;
    logic            irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;   // 250 MHz

    adc_evt_flags dut (
        .clk(clk), .rst_n(rst_n), .eoc(eoc), .result(result),
        .trip_hi(trip_hi), .trip_lo(trip_lo), .clr(clr),
        .int_en(int_en), .status(status), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One cycle: inputs applied at a falling edge, cleared at the next one.
    task automatic step(input logic [NCH-1:0] e, input logic [NCH-1:0] th,
                        input logic [NCH-1:0] tl, input logic [SW-1:0] c);
        @(negedge clk);
        eoc = e; trip_hi = th; trip_lo = tl; clr = c;
        @(negedge clk);
        eoc = '0; trip_hi = '0; trip_lo = '0; clr = '0;
    endtask

    task automatic set_res(input int ch, input logic [15:0] v);
        result[ch*RW +: RW] = v;
    endtask

    task automatic clear_all();
        step('0, '0, '0, '1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; eoc = '0; trip_hi = '0; trip_lo = '0;
        clr = '0; int_en = '0; result = '0;
        repeat (3) @(negedge clk);
        check("R2 status after reset", 32'(status), 32'h0);
        check("R2 irq after reset", 32'(irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 status stays zero", 32'(status), 32'h0);
    endtask

    task automatic t_trips();
        step('0, 4'b0001, '0, '0);
        check("R3 R1 trip-high ch0 bit0", 32'(status), 32'h0001);
        step('0, '0, 4'b0100, '0);
        check("R3 R1 trip-low ch2 bit9", 32'(status), 32'h0201);
        check("R7 irq stays low with enables off", 32'(irq), 32'h0);
        repeat (3) @(negedge clk);
        check("R7 flags sticky", 32'(status), 32'h0201);
        step('0, '1, '1, '0);
        check("R1 all trips, reserved zero", 32'(status), 32'h3333);
        clear_all();
        check("R8 clear all", 32'(status), 32'h0);
    endtask

    task automatic t_zero_cross();
        set_res(1, POS);
        step(4'b0010, '0, '0, '0);
        check("R6 first eoc primes only", 32'(status), 32'h0);
        set_res(1, NEG);
        step(4'b0010, '0, '0, '0);
        check("R4 sign change ch1 bit6", 32'(status), 32'h0040);
        clear_all();
        set_res(1, POS);
        repeat (4) @(negedge clk);
        check("R5 no eoc no flag", 32'(status), 32'h0);
        set_res(1, NEG);
        @(negedge clk);
        set_res(1, POS);
        step(4'b0010, '0, '0, '0);
        check("R4 stored sign negative, now positive", 32'(status), 32'h0040);
        clear_all();
        step(4'b0010, '0, '0, '0);
        check("R4 same sign no flag", 32'(status), 32'h0);
        set_res(3, NEG);
        step(4'b1000, '0, '0, '0);
        check("R6 first eoc negative ch3", 32'(status), 32'h0);
        step(4'b1000, '0, '0, '0);
        check("R4 repeated negative no flag", 32'(status), 32'h0);
        set_res(3, POS);
        step(4'b1000, '0, '0, '0);
        check("R4 ch3 crossing bit14", 32'(status), 32'h4000);
        clear_all();
    endtask

    task automatic t_clear();
        step('0, 4'b0001, 4'b0010, '0);
        check("R3 setup hi ch0 lo ch1", 32'(status), 32'h0021);
        step('0, '0, '0, 16'h0001);
        check("R8 clear one bit", 32'(status), 32'h0020);
        step('0, '0, '0, 16'h0000);
        check("R8 zero clear no effect", 32'(status), 32'h0020);
        step('0, '0, '0, 16'h8888);
        check("R8 reserved clear ignored", 32'(status), 32'h0020);
        clear_all();
    endtask

    task automatic t_collision();
        step('0, 4'b0100, '0, 16'h0100);
        check("R9 set beats clear trip", 32'(status), 32'h0100);
        set_res(0, POS);
        step(4'b0001, '0, '0, '0);
        set_res(0, NEG);
        step(4'b0001, '0, '0, 16'h0004);
        check("R9 set beats clear zero-cross", 32'(status), 32'h0104);
        clear_all();
    endtask

    task automatic t_irq();
        step('0, 4'b0100, '0, '0);
        @(negedge clk); int_en = 16'h0100;
        @(negedge clk);
        check("R10 irq enabled pending", 32'(irq), 32'h1);
        repeat (3) @(negedge clk);
        check("R10 irq holds as level", 32'(irq), 32'h1);
        int_en = 16'h0001;
        @(negedge clk);
        check("R10 irq masked", 32'(irq), 32'h0);
        check("R7 flag kept while masked", 32'(status), 32'h0100);
        int_en = 16'h0100;
        step('0, '0, '0, 16'h0100);
        check("R10 irq drops after clear", 32'(irq), 32'h0);
        int_en = '0;
    endtask

    initial begin
        t_reset();
        t_trips();
        t_zero_cross();
        t_clear();
        t_collision();
        t_irq();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule